// File: doc/BRIEF.md
# Split-Address Window Permission Guard

This block sits beside a bus port and checks every access that falls inside one fixed address window. A programmable split address cuts the window in two: addresses below the split use the lower region's permission set, addresses at or above it use the upper region's set. Each set allows or forbids reads, writes and instruction fetches on its own. Accesses outside the window always pass and are never reported.

When an access inside the window is not allowed, the guard drops the grant and raises a deny strobe in the same cycle. The first such violation is latched into a fault status word: the low address bits, a write flag, a fetch flag and a base flag. A pending bit is set, and the interrupt line follows it when the enable bit is on. Software clears the pending state by raising and then dropping a clear bit. A lock bit, once set, freezes the configuration and the interrupt enable until reset. Clearing the interrupt still works while locked.

Top module: `splitwin_guard`

## Requirements
- R1: Inside the window, an address strictly below the split address is judged by the lower permission set, and an address equal to or above it by the upper set; `acc_grant` and `acc_deny` respond combinationally in the same cycle as `acc_req`.
- R2: A configuration write (`reg_sel`=1) places the split address in bits [23:0] and the permissions in bits 24 (lower read), 25 (lower write), 26 (lower fetch), 27 (upper read), 28 (upper write) and 29 (upper fetch). Reading it back gives the same layout. The reset value is split = window start with all six permissions set. `acc_op` is coded 0 = read, 1 = write, 2 or 3 = fetch.
- R3: Any request whose address lies outside [0x400000, 0x400FFF] is granted, never denied, and never sets the pending bit.
- R4: A configuration write whose split address lies outside the window is ignored, and the previous configuration remains.
- R5: A configuration write whose split address is not a multiple of 4 is ignored.
- R6: A denied access sets the pending bit (control bit 2, `reg_sel`=2) at the next clock edge. `irq` equals pending AND the enable bit (control bit 0).
- R7: While control bit 1 (clear) reads 1, the pending bit is forced low at each clock edge and no new violation is recorded. Writing 0 to it re-arms capture.
- R8: The fault status word (`reg_sel`=3, read-only) holds the faulting address's 12 low bits in [11:0], a write flag in bit 16, a fetch flag in bit 17 and a base flag in bit 18. `fault_addr` rebuilds the full address as the low bits ORed with the window base 0x400000 when the base flag is set, and 0 otherwise.
- R9: Only the first violation since the last clear is recorded. Later violations leave the fault status unchanged while pending is set.
- R10: Writing 1 to bit 0 of the lock register (`reg_sel`=0) sets the lock, which reads back in bit 0. A later write of 0 does not clear it; only reset does.
- R11: While locked, configuration writes and changes to the enable bit are ignored, but the clear bit still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Access request valid |
| acc_addr | input | 24 | Access byte address |
| acc_op | input | 2 | Access kind: 0 read, 1 write, 2/3 fetch |
| acc_grant | output | 1 | Access permitted |
| acc_deny | output | 1 | Access inside window and refused |
| reg_wen | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 lock, 1 config, 2 control, 3 fault status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Violation interrupt |
| fault_addr | output | 24 | Rebuilt address of the recorded violation |

## Verification
A bad split or permission register shows up at once as a wrong grant/deny on the next probe on either side of the split, and in the configuration readback. A wrong pending or capture state is visible one edge after the offending access, through `irq`, control bit 2 and the fault status word. A lock that leaks lets a rejected write change the readback within one cycle. The directed tests probe the addresses just below and at the split, both window edges, rejected split values and every operation kind, so that each of these faults shows at the ports.

// File: rtl/splitwin_pkg.sv
package splitwin_pkg;

  parameter int unsigned SW_ADDR_W = 24;
  parameter int unsigned SW_DATA_W = 32;

  typedef logic [SW_ADDR_W-1:0] addr_t;

  // one permission triple, bit 0 read, bit 1 write, bit 2 fetch
  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm3_t;

  typedef enum logic [1:0] {
    OP_RD   = 2'd0,
    OP_WR   = 2'd1,
    OP_FX   = 2'd2,
    OP_FX_B = 2'd3
  } acc_op_e;

  typedef enum logic [1:0] {
    SEL_LOCK = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_FLT  = 2'd3
  } reg_sel_e;

  localparam int unsigned CFG_PLO_LSB = SW_ADDR_W;
  localparam int unsigned CFG_PHI_LSB = SW_ADDR_W + 3;
  localparam int unsigned FLT_WR_BIT  = 16;
  localparam int unsigned FLT_FX_BIT  = 17;
  localparam int unsigned FLT_BS_BIT  = 18;

  function automatic logic in_range(addr_t a, addr_t lo, addr_t hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic split_ok(addr_t a, addr_t lo, addr_t hi);
    return in_range(a, lo, hi) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic perm_allows(perm3_t p, logic [1:0] op);
    logic ok;
    case (op)
      OP_RD:   ok = p.r;
      OP_WR:   ok = p.w;
      default: ok = p.x;
    endcase
    return ok;
  endfunction

  function automatic addr_t rebuild_addr(addr_t low, logic flag, addr_t base);
    return low | (flag ? base : '0);
  endfunction

endpackage

// File: rtl/swg_cfg_regs.sv
module swg_cfg_regs
  import splitwin_pkg::*;
#(
  parameter addr_t WIN_LO = 24'h40_0000,
  parameter addr_t WIN_HI = 24'h40_0FFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wen,
  input  logic [1:0]           sel,
  input  logic [SW_DATA_W-1:0] wdata,
  output logic                 lock_q,
  output addr_t                split_q,
  output perm3_t               perm_lo,
  output perm3_t               perm_hi,
  output logic                 irq_en,
  output logic                 clr_q
);

  addr_t wr_split;
  logic  wr_lock, wr_cfg, wr_ctl;
  logic  unused_wdata;

  assign wr_split     = wdata[SW_ADDR_W-1:0];
  assign wr_lock      = wen && (sel == SEL_LOCK) && wdata[0];
  assign wr_cfg       = wen && (sel == SEL_CFG) && !lock_q &&
                        split_ok(wr_split, WIN_LO, WIN_HI);
  assign wr_ctl       = wen && (sel == SEL_CTL);
  assign unused_wdata = ^wdata[SW_DATA_W-1:CFG_PHI_LSB+3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (wr_lock) begin
      lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      split_q <= WIN_LO;
      perm_lo <= '1;
      perm_hi <= '1;
    end else if (wr_cfg) begin
      split_q <= wr_split;
      perm_lo <= wdata[CFG_PLO_LSB +: 3];
      perm_hi <= wdata[CFG_PHI_LSB +: 3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
      clr_q  <= 1'b0;
    end else if (wr_ctl) begin
      clr_q <= wdata[1];
      if (!lock_q) irq_en <= wdata[0];
    end
  end

  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(split_q) && $stable(perm_lo) && $stable(perm_hi) && $stable(irq_en)));

  p_split_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (split_q >= WIN_LO) && (split_q <= WIN_HI));

  p_split_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    split_q[1:0] == 2'b00);

endmodule

// File: rtl/swg_perm_check.sv
module swg_perm_check
  import splitwin_pkg::*;
#(
  parameter addr_t WIN_LO = 24'h40_0000,
  parameter addr_t WIN_HI = 24'h40_0FFF
) (
  input  logic       req,
  input  addr_t      addr,
  input  logic [1:0] op,
  input  addr_t      split,
  input  perm3_t     perm_lo,
  input  perm3_t     perm_hi,
  output logic       hit_high,
  output logic       grant,
  output logic       deny
);

  logic   in_win, allowed;
  perm3_t sel_perm;

  assign in_win   = in_range(addr, WIN_LO, WIN_HI);
  assign hit_high = in_win && (addr >= split);
  assign sel_perm = hit_high ? perm_hi : perm_lo;
  assign allowed  = perm_allows(sel_perm, op);
  assign grant    = req && (!in_win || allowed);
  assign deny     = req && in_win && !allowed;

endmodule

// File: rtl/swg_fault_cap.sv
module swg_fault_cap
  import splitwin_pkg::*;
#(
  parameter int unsigned OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             deny,
  input  logic [OFF_W-1:0] addr_low,
  input  logic [1:0]       op,
  input  logic             clr_q,
  input  logic             irq_en,
  output logic             pending,
  output logic [OFF_W-1:0] flt_off,
  output logic             flt_wr,
  output logic             flt_fx,
  output logic             flt_base,
  output logic             irq
);

  logic capture;

  assign capture = deny && !pending && !clr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      flt_off  <= '0;
      flt_wr   <= 1'b0;
      flt_fx   <= 1'b0;
      flt_base <= 1'b0;
    end else if (clr_q) begin
      pending <= 1'b0;
    end else if (capture) begin
      pending  <= 1'b1;
      flt_off  <= addr_low;
      flt_wr   <= (op == OP_WR);
      flt_fx   <= op[1];
      flt_base <= 1'b1;
    end
  end

  assign irq = pending && irq_en;

  p_first_fault_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr_q) |=> ($stable(flt_off) && $stable(flt_wr) && $stable(flt_fx)));

  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !pending);

endmodule

// File: rtl/splitwin_guard.sv
module splitwin_guard
  import splitwin_pkg::*;
#(
  parameter addr_t       WIN_LO = 24'h40_0000,
  parameter addr_t       WIN_HI = 24'h40_0FFF,
  parameter int unsigned OFF_W  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_req,
  input  logic [SW_ADDR_W-1:0] acc_addr,
  input  logic [1:0]           acc_op,
  output logic                 acc_grant,
  output logic                 acc_deny,
  input  logic                 reg_wen,
  input  logic [1:0]           reg_sel,
  input  logic [SW_DATA_W-1:0] reg_wdata,
  output logic [SW_DATA_W-1:0] reg_rdata,
  output logic                 irq,
  output logic [SW_ADDR_W-1:0] fault_addr
);

  localparam addr_t OFF_MASK = addr_t'((64'd1 << OFF_W) - 64'd1);
  localparam addr_t WIN_BASE = WIN_LO & ~OFF_MASK;

  logic             lock_q, irq_en, clr_q, pending, hit_high;
  addr_t            split_q;
  perm3_t           perm_lo, perm_hi;
  logic [OFF_W-1:0] flt_off;
  logic             flt_wr, flt_fx, flt_base;
  logic             unused_hit;

  swg_cfg_regs #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .sel(reg_sel), .wdata(reg_wdata),
    .lock_q(lock_q), .split_q(split_q), .perm_lo(perm_lo), .perm_hi(perm_hi),
    .irq_en(irq_en), .clr_q(clr_q)
  );

  swg_perm_check #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_chk (
    .req(acc_req), .addr(acc_addr), .op(acc_op), .split(split_q),
    .perm_lo(perm_lo), .perm_hi(perm_hi), .hit_high(hit_high),
    .grant(acc_grant), .deny(acc_deny)
  );

  swg_fault_cap #(.OFF_W(OFF_W)) u_flt (
    .clk(clk), .rst_n(rst_n), .deny(acc_deny), .addr_low(acc_addr[OFF_W-1:0]),
    .op(acc_op), .clr_q(clr_q), .irq_en(irq_en), .pending(pending),
    .flt_off(flt_off), .flt_wr(flt_wr), .flt_fx(flt_fx), .flt_base(flt_base),
    .irq(irq)
  );

  assign unused_hit = hit_high;
  assign fault_addr = rebuild_addr(addr_t'(flt_off), flt_base, WIN_BASE);

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_LOCK: reg_rdata[0] = lock_q;
      SEL_CFG: begin
        reg_rdata[SW_ADDR_W-1:0]   = split_q;
        reg_rdata[CFG_PLO_LSB +: 3] = perm_lo;
        reg_rdata[CFG_PHI_LSB +: 3] = perm_hi;
      end
      SEL_CTL:  reg_rdata[2:0] = {pending, clr_q, irq_en};
      default: begin
        reg_rdata[OFF_W-1:0] = flt_off;
        reg_rdata[FLT_WR_BIT] = flt_wr;
        reg_rdata[FLT_FX_BIT] = flt_fx;
        reg_rdata[FLT_BS_BIT] = flt_base;
      end
    endcase
  end

  p_deny_pends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_deny && !clr_q) |=> pending);

  p_outside_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && ((acc_addr < WIN_LO) || (acc_addr > WIN_HI))) |-> (acc_grant && !acc_deny));

endmodule

// File: tb/test_splitwin_guard.sv
module test_splitwin_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_req = 1'b0;
  logic [23:0] acc_addr = '0;
  logic [1:0]  acc_op = '0;
  logic        acc_grant, acc_deny;
  logic        reg_wen = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [23:0] fault_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  splitwin_guard i_splitwin_guard (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_addr(acc_addr),
    .acc_op(acc_op), .acc_grant(acc_grant), .acc_deny(acc_deny),
    .reg_wen(reg_wen), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .fault_addr(fault_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_wen = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [31:0] data);
    reg_sel = sel;
    #1;
    data = reg_rdata;
  endtask

  // drives one access cycle; returns grant/deny seen before the edge
  task automatic access(input logic [23:0] a, input logic [1:0] op,
                        output logic g, output logic d);
    @(negedge clk);
    acc_req = 1'b1; acc_addr = a; acc_op = op;
    #1;
    g = acc_grant; d = acc_deny;
    @(negedge clk);
    acc_req = 1'b0;
  endtask

  task automatic probe(input string tag, input logic [23:0] a, input logic [1:0] op,
                       input logic eg, input logic ed);
    logic g, d;
    access(a, op, g, d);
    chk(tag, {30'b0, g, d}, {30'b0, eg, ed});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    reg_read(2'd1, v); chk("R2 reset config", v, 32'h3F40_0000);
    reg_read(2'd0, v); chk("R10 reset lock", v, 32'h0);
    reg_read(2'd2, v); chk("R6 reset control", v, 32'h0);
    reg_read(2'd3, v); chk("R8 reset fault", v, 32'h0);
    chk("R6 reset irq", {31'b0, irq}, 32'h0);
    chk("R8 reset fault_addr", {8'b0, fault_addr}, 32'h0);
  endtask

  task automatic t_regions;
    logic [31:0] v;
    reg_write(2'd1, 32'h3140_0800);
    reg_read(2'd1, v); chk("R2 config readback", v, 32'h3140_0800);
    probe("R1 low read", 24'h4007FC, 2'd0, 1'b1, 1'b0);
    probe("R1 low write", 24'h4007FC, 2'd1, 1'b0, 1'b1);
    probe("R1 low fetch", 24'h4007FC, 2'd2, 1'b0, 1'b1);
    probe("R1 split read", 24'h400800, 2'd0, 1'b0, 1'b1);
    probe("R1 split write", 24'h400800, 2'd1, 1'b1, 1'b0);
    probe("R2 high fetch op2", 24'h400800, 2'd2, 1'b1, 1'b0);
    probe("R2 high fetch op3", 24'h400800, 2'd3, 1'b1, 1'b0);
    reg_read(2'd3, v); chk("R9 first fault kept", v, 32'h0005_07FC);
    chk("R8 fault_addr rebuilt", {8'b0, fault_addr}, 32'h0040_07FC);
    reg_read(2'd2, v); chk("R6 pending without enable", v, 32'h4);
    chk("R6 irq gated off", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_clear_outside;
    logic [31:0] v;
    reg_write(2'd2, 32'h2);
    reg_write(2'd2, 32'h0);
    reg_read(2'd2, v); chk("R7 clear pulse", v, 32'h0);
    probe("R3 below window write", 24'h3FFFFC, 2'd1, 1'b1, 1'b0);
    probe("R3 above window write", 24'h401000, 2'd1, 1'b1, 1'b0);
    probe("R3 below window fetch", 24'h3FFFFC, 2'd2, 1'b1, 1'b0);
    reg_read(2'd2, v); chk("R3 no pending", v, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    reg_write(2'd2, 32'h1);
    chk("R6 enabled idle irq", {31'b0, irq}, 32'h0);
    probe("R1 high read denied", 24'h400900, 2'd0, 1'b0, 1'b1);
    chk("R6 irq raised", {31'b0, irq}, 32'h1);
    reg_read(2'd2, v); chk("R6 control pending", v, 32'h5);
    reg_read(2'd3, v); chk("R8 read fault", v, 32'h0004_0900);
    chk("R8 fault_addr read", {8'b0, fault_addr}, 32'h0040_0900);
    reg_write(2'd2, 32'h3);
    probe("R7 deny during clear", 24'h400004, 2'd2, 1'b0, 1'b1);
    reg_read(2'd2, v); chk("R7 nothing captured in clear", v, 32'h3);
    chk("R7 irq low in clear", {31'b0, irq}, 32'h0);
    reg_write(2'd2, 32'h1);
    probe("R1 low fetch denied", 24'h400004, 2'd2, 1'b0, 1'b1);
    reg_read(2'd3, v); chk("R8 fetch fault", v, 32'h0006_0004);
    chk("R6 irq again", {31'b0, irq}, 32'h1);
    reg_write(2'd2, 32'h3);
    reg_write(2'd2, 32'h1);
    chk("R7 irq cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_reject;
    logic [31:0] v;
    reg_write(2'd1, 32'h3F3F_FFFC);
    reg_read(2'd1, v); chk("R4 split below window", v, 32'h3140_0800);
    reg_write(2'd1, 32'h3F40_1000);
    reg_read(2'd1, v); chk("R4 split above window", v, 32'h3140_0800);
    reg_write(2'd1, 32'h3F40_0802);
    reg_read(2'd1, v); chk("R5 unaligned split", v, 32'h3140_0800);
    reg_write(2'd1, 32'h0740_0FFC);
    reg_read(2'd1, v); chk("R4 top aligned split", v, 32'h0740_0FFC);
    probe("R1 below top split", 24'h400FF8, 2'd1, 1'b1, 1'b0);
    probe("R1 at top split", 24'h400FFC, 2'd0, 1'b0, 1'b1);
    reg_write(2'd2, 32'h3);
    reg_write(2'd2, 32'h1);
  endtask

  task automatic t_lock;
    logic [31:0] v;
    reg_write(2'd0, 32'h1);
    reg_read(2'd0, v); chk("R10 lock set", v, 32'h1);
    reg_write(2'd0, 32'h0);
    reg_read(2'd0, v); chk("R10 lock sticky", v, 32'h1);
    reg_write(2'd1, 32'h3F40_0000);
    reg_read(2'd1, v); chk("R11 config frozen", v, 32'h0740_0FFC);
    reg_write(2'd2, 32'h0);
    reg_read(2'd2, v); chk("R11 enable frozen", v, 32'h1);
    probe("R11 deny while locked", 24'h400FFC, 2'd0, 1'b0, 1'b1);
    chk("R11 irq while locked", {31'b0, irq}, 32'h1);
    reg_write(2'd2, 32'h2);
    reg_write(2'd2, 32'h0);
    reg_read(2'd2, v); chk("R11 clear allowed", v, 32'h1);
    chk("R11 irq cleared", {31'b0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    reg_read(2'd0, v); chk("R10 reset unlocks", v, 32'h0);
    reg_read(2'd1, v); chk("R2 config after reset", v, 32'h3F40_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regions();
    t_clear_outside();
    t_irq();
    t_reject();
    t_lock();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule